// File: doc/BRIEF.md
# Watchdog Clock Health Monitor

This block checks that the free-running clock feeding a watchdog is alive and near its expected rate. The monitored clock enters the reference-clock domain through a two-stage synchronizer. A rising-edge detector then feeds a counter that runs over a probe window of a programmable number of reference cycles. At the end of each window the count is graded into one of five classes: healthy, stuck, stopped, too slow or too fast. The slow and fast limits sit a programmable tolerance below and above a nominal count.

A single bad window does not declare failure. Failure is declared only when a programmable number of windows in a row are bad, with a floor of three. A one-cycle clock-fail event is then raised toward the warning (bark) path, and a saturating failure counter advances. One healthy window clears both the run of bad windows and the failure flag.

A sticky production lock freezes the probe length, nominal count, tolerance and run length. Once the lock is set, the failure counter can no longer be cleared. All pins are plain control and status signals. No data stream passes through the block, so there is no back-pressure.

Top module: `wdclk_health_mon`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `clk_fail_o`=0, `clkfail_evt_o`=0, `clk_class_o`=0 and `fail_cnt_o`=0.
- R2: A probe window lasts `cfg_probe_len_i` reference cycles. Any value below 4 is treated as 4. `clk_class_o` is updated once, at the last cycle of each window.
- R3: Each rising edge of `mon_clk_i` is counted exactly once, after a two-flop synchronizer. A steady clock whose period divides the window evenly gives the same count in every window.
- R4: Class codes: 0 = healthy. 1 = stuck: no edge of either polarity in the window. 2 = stopped: zero rising edges but at least one falling edge. 3 = slow: count < nom − floor(nom·tol/256). 4 = fast: count > nom + floor(nom·tol/256). Priority is stuck/stopped, then slow, then fast.
- R5: A count exactly equal to either tolerance limit is graded healthy.
- R6: `clk_fail_o` rises at the end of the M-th bad window in a row, where M = max(`cfg_consec_i`, 3). A healthy window resets the run and clears `clk_fail_o`.
- R7: `clkfail_evt_o` pulses for one cycle in the cycle that `clk_fail_o` rises. It does not pulse again while the failure persists, even if the failure class changes.
- R8: `fail_cnt_o` increments by one on each event and saturates at all ones.
- R9: `cnt_clr_i` zeroes `fail_cnt_o` on the next cycle while unlocked. Once locked, it is ignored.
- R10: `prod_lock_i` sets a lock that holds until reset. After the lock is set, changes on the four configuration inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock |
| rst_ref_n_i | input | 1 | Asynchronous active-low reset |
| mon_clk_i | input | 1 | Monitored watchdog clock (asynchronous) |
| cfg_probe_len_i | input | 16 | Probe window length in reference cycles |
| cfg_nominal_i | input | 16 | Expected edge count per window |
| cfg_tol_i | input | 8 | Tolerance in 1/256 units of nominal |
| cfg_consec_i | input | 4 | Bad windows in a row needed to fail (floor 3) |
| prod_lock_i | input | 1 | Sets the sticky production lock |
| cnt_clr_i | input | 1 | Clears the failure counter when unlocked |
| clk_fail_o | output | 1 | Clock failure declared |
| clkfail_evt_o | output | 1 | One-cycle event on failure declaration |
| clk_class_o | output | 3 | Class of the last completed window |
| fail_cnt_o | output | 8 | Saturating failure counter |

## Verification
The stopped class is the hardest to reach from the ports. It needs a window in which the monitored clock falls once and never rises, so the single falling edge must land inside one window and no rising edge may spill in from the one before. The bench uses its own reference model's window position to line up with a boundary. It holds the clock high for two whole windows, then drops it mid-window and keeps it low. Counter saturation is reached by repeating short stuck and healthy bursts with a four-cycle window until more than 255 failures have been declared.

// File: rtl/wdclk_mon_pkg.sv
package wdclk_mon_pkg;
  typedef enum logic [2:0] {
    CLS_OK    = 3'd0,
    CLS_STUCK = 3'd1,
    CLS_STOP  = 3'd2,
    CLS_SLOW  = 3'd3,
    CLS_FAST  = 3'd4
  } clk_class_e;
endpackage

// File: rtl/wdclk_edge_sync.sv
module wdclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  // STAGES flops of synchronizer plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sh_q <= '0;
    else          sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/wdclk_probe.sv
module wdclk_probe #(
  parameter int WIN_W   = 16,
  parameter int CNT_W   = 16,
  parameter int MIN_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [WIN_W-1:0] len_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fell_o
);
  localparam logic [WIN_W-1:0] LEN_FLOOR = WIN_W'(MIN_LEN);

  logic [WIN_W-1:0] wcnt_q;
  logic [WIN_W-1:0] eff_len;
  logic [CNT_W-1:0] rises_q, rises_sum;
  logic             fell_q;

  assign eff_len   = (len_i < LEN_FLOOR) ? LEN_FLOOR : len_i;
  assign done_o    = (wcnt_q >= eff_len - 1'b1);
  assign rises_sum = (rises_q == '1) ? rises_q : rises_q + CNT_W'(rise_i);
  assign cnt_o     = rises_sum;
  assign fell_o    = fell_q | fall_i;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      wcnt_q  <= '0;
      rises_q <= '0;
      fell_q  <= 1'b0;
    end else if (done_o) begin
      wcnt_q  <= '0;
      rises_q <= '0;
      fell_q  <= 1'b0;
    end else begin
      wcnt_q  <= wcnt_q + 1'b1;
      rises_q <= rises_sum;
      fell_q  <= fell_o;
    end
  end
endmodule

// File: rtl/wdclk_classify.sv
module wdclk_classify
  import wdclk_mon_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TOL_W = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             fell_i,
  input  logic [CNT_W-1:0] nom_i,
  input  logic [TOL_W-1:0] tol_i,
  output clk_class_e       cls_o
);
  localparam int PROD_W = CNT_W + TOL_W;

  logic [PROD_W-1:0] prod;
  logic [CNT_W-1:0]  dev;
  logic [CNT_W:0]    lo_lim, hi_lim, cnt_x;

  assign prod   = PROD_W'(nom_i) * PROD_W'(tol_i);
  assign dev    = prod[PROD_W-1:TOL_W];
  assign lo_lim = {1'b0, nom_i} - {1'b0, dev};
  assign hi_lim = {1'b0, nom_i} + {1'b0, dev};
  assign cnt_x  = {1'b0, cnt_i};

  always_comb begin
    if (cnt_i == '0)          cls_o = fell_i ? CLS_STOP : CLS_STUCK;
    else if (cnt_x < lo_lim)  cls_o = CLS_SLOW;
    else if (cnt_x > hi_lim)  cls_o = CLS_FAST;
    else                      cls_o = CLS_OK;
  end
endmodule

// File: rtl/wdclk_verdict.sv
module wdclk_verdict
  import wdclk_mon_pkg::*;
#(
  parameter int M_W    = 4,
  parameter int M_MIN  = 3,
  parameter int FCNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              done_i,
  input  clk_class_e        cls_i,
  input  logic [M_W-1:0]    m_req_i,
  input  logic              clr_en_i,
  output logic              fail_o,
  output logic              evt_o,
  output clk_class_e        cls_o,
  output logic [FCNT_W-1:0] fcnt_o
);
  localparam logic [M_W-1:0] M_FLOOR = M_W'(M_MIN);

  logic [M_W-1:0] m_eff, run_q, run_inc;
  logic           bad, declare;

  assign m_eff   = (m_req_i < M_FLOOR) ? M_FLOOR : m_req_i;
  assign bad     = (cls_i != CLS_OK);
  assign run_inc = (run_q == '1) ? run_q : run_q + 1'b1;
  assign declare = done_i && bad && !fail_o && (run_inc >= m_eff);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      run_q  <= '0;
      fail_o <= 1'b0;
      cls_o  <= CLS_OK;
    end else if (done_i) begin
      cls_o <= cls_i;
      if (bad) begin
        run_q <= run_inc;
        if (declare) fail_o <= 1'b1;
      end else begin
        run_q  <= '0;
        fail_o <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      evt_o  <= 1'b0;
      fcnt_o <= '0;
    end else begin
      evt_o <= declare;
      if (clr_en_i)                       fcnt_o <= '0;
      else if (declare && fcnt_o != '1)   fcnt_o <= fcnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/wdclk_health_mon.sv
module wdclk_health_mon
  import wdclk_mon_pkg::*;
#(
  parameter int WIN_W     = 16,
  parameter int CNT_W     = 16,
  parameter int TOL_W     = 8,
  parameter int M_W       = 4,
  parameter int M_MIN     = 3,
  parameter int FCNT_W    = 8,
  parameter int SYNC_STG  = 2,
  parameter int MIN_LEN   = 4
) (
  input  logic              clk_ref_i,
  input  logic              rst_ref_n_i,
  input  logic              mon_clk_i,
  input  logic [WIN_W-1:0]  cfg_probe_len_i,
  input  logic [CNT_W-1:0]  cfg_nominal_i,
  input  logic [TOL_W-1:0]  cfg_tol_i,
  input  logic [M_W-1:0]    cfg_consec_i,
  input  logic              prod_lock_i,
  input  logic              cnt_clr_i,
  output logic              clk_fail_o,
  output logic              clkfail_evt_o,
  output logic [2:0]        clk_class_o,
  output logic [FCNT_W-1:0] fail_cnt_o
);
  logic [WIN_W-1:0] len_q;
  logic [CNT_W-1:0] nom_q;
  logic [TOL_W-1:0] tol_q;
  logic [M_W-1:0]   m_q;
  logic             lock_q;

  // Configuration shadow: follows the inputs until the lock is set
  always_ff @(posedge clk_ref_i or negedge rst_ref_n_i) begin
    if (!rst_ref_n_i) begin
      len_q  <= WIN_W'(MIN_LEN);
      nom_q  <= '0;
      tol_q  <= '0;
      m_q    <= M_W'(M_MIN);
      lock_q <= 1'b0;
    end else begin
      if (!lock_q) begin
        len_q <= cfg_probe_len_i;
        nom_q <= cfg_nominal_i;
        tol_q <= cfg_tol_i;
        m_q   <= cfg_consec_i;
      end
      lock_q <= lock_q | prod_lock_i;
    end
  end

  logic             rise, fall, done, fell;
  logic [CNT_W-1:0] cnt;
  clk_class_e       cls_now, cls_last;

  wdclk_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_ref_i), .rst_n_i(rst_ref_n_i), .async_i(mon_clk_i),
    .rise_o(rise), .fall_o(fall)
  );

  wdclk_probe #(.WIN_W(WIN_W), .CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) u_probe (
    .clk_i(clk_ref_i), .rst_n_i(rst_ref_n_i), .rise_i(rise), .fall_i(fall),
    .len_i(len_q), .done_o(done), .cnt_o(cnt), .fell_o(fell)
  );

  wdclk_classify #(.CNT_W(CNT_W), .TOL_W(TOL_W)) u_class (
    .cnt_i(cnt), .fell_i(fell), .nom_i(nom_q), .tol_i(tol_q), .cls_o(cls_now)
  );

  wdclk_verdict #(.M_W(M_W), .M_MIN(M_MIN), .FCNT_W(FCNT_W)) u_verdict (
    .clk_i(clk_ref_i), .rst_n_i(rst_ref_n_i), .done_i(done), .cls_i(cls_now),
    .m_req_i(m_q), .clr_en_i(cnt_clr_i & ~lock_q),
    .fail_o(clk_fail_o), .evt_o(clkfail_evt_o), .cls_o(cls_last),
    .fcnt_o(fail_cnt_o)
  );

  assign clk_class_o = cls_last;
endmodule

// File: rtl/wdclk_health_mon_chk.sv
module wdclk_health_mon_chk #(
  parameter int FCNT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fail,
  input logic              evt,
  input logic [2:0]        cls,
  input logic [FCNT_W-1:0] fcnt,
  input logic              lock_q,
  input logic              clr
);
  // R7: event coincides with the rise of the failure flag
  a_r7_evt_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (fail && !$past(fail)));
  a_r7_rise_has_evt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> evt);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
  // R6: failure flag only while the last window was bad
  a_r6_fail_bad_cls: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (cls != 3'd0));
  // R4: class code in range
  a_r4_cls_range: assert property (@(posedge clk) disable iff (!rst_n)
    cls <= 3'd4);
  // R8: counter steps by one on an event
  a_r8_inc_one: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !($past(clr) && !$past(lock_q)) && ($past(fcnt) != '1))
      |-> (fcnt == FCNT_W'($past(fcnt) + 1'b1)));
  // R8: saturated counter stays saturated once clearing is locked out
  a_r8_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && fcnt == '1) |=> (fcnt == '1));
  // R10: lock is sticky
  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
endmodule

bind wdclk_health_mon wdclk_health_mon_chk #(.FCNT_W(FCNT_W)) u_chk (
  .clk(clk_ref_i), .rst_n(rst_ref_n_i), .fail(clk_fail_o), .evt(clkfail_evt_o),
  .cls(clk_class_o), .fcnt(fail_cnt_o), .lock_q(lock_q), .clr(cnt_clr_i)
);

// File: tb/wdclk_health_mon_tb_top.sv
`timescale 1ns/1ps
module wdclk_health_mon_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mon_clk = 1'b0;
  logic [15:0] cfg_len = 16'd40;
  logic [15:0] cfg_nom = 16'd10;
  logic [7:0]  cfg_tol = 8'd26;
  logic [3:0]  cfg_m = 4'd3;
  logic        lock_in = 1'b0;
  logic        clr_in = 1'b0;
  logic        fail_o, evt_o;
  logic [2:0]  cls_o;
  logic [7:0]  fcnt_o;

  always #2 clk = ~clk;  // 250 MHz

  wdclk_health_mon dut_i (
    .clk_ref_i(clk), .rst_ref_n_i(rst_n), .mon_clk_i(mon_clk),
    .cfg_probe_len_i(cfg_len), .cfg_nominal_i(cfg_nom), .cfg_tol_i(cfg_tol),
    .cfg_consec_i(cfg_m), .prod_lock_i(lock_in), .cnt_clr_i(clr_in),
    .clk_fail_o(fail_o), .clkfail_evt_o(evt_o), .clk_class_o(cls_o),
    .fail_cnt_o(fcnt_o)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitored clock generator: toggles every mon_half reference cycles, 0 = hold
  int mon_half = 2;
  int ph = 0;
  always @(negedge clk) begin
    if (mon_half != 0) begin
      if (ph >= mon_half - 1) begin mon_clk = ~mon_clk; ph = 0; end
      else ph++;
    end
  end

  // Inputs as seen at each rising edge
  bit p_rst, p_mon, p_lock, p_clr;
  int p_len, p_nom, p_tol, p_m;
  always @(posedge clk) begin
    p_rst = rst_n; p_mon = mon_clk; p_lock = lock_in; p_clr = clr_in;
    p_len = cfg_len; p_nom = cfg_nom; p_tol = cfg_tol; p_m = cfg_m;
  end

  // Behavioural reference model, advanced once per cycle
  bit hq[$] = '{0, 0, 0};
  int m_len = 4, m_nom = 0, m_tol = 0, m_m = 3;
  bit m_lock = 0;
  int m_wcnt = 0, m_rises = 0, m_run = 0, m_cls = 0, m_fcnt = 0;
  bit m_fell = 0, m_fail = 0, m_evt = 0;
  int win_ends = 0;
  int evt_seen = 0;

  always @(negedge clk) begin
    if (!p_rst) begin
      hq = '{0, 0, 0};
      m_len = 4; m_nom = 0; m_tol = 0; m_m = 3; m_lock = 0;
      m_wcnt = 0; m_rises = 0; m_fell = 0; m_run = 0; m_cls = 0;
      m_fail = 0; m_evt = 0; m_fcnt = 0;
    end else begin
      bit rise_now, fall_now, declare;
      int eff, sum, dev, cls, mreq;
      rise_now = hq[1] && !hq[2];
      fall_now = !hq[1] && hq[2];
      eff = (m_len < 4) ? 4 : m_len;
      sum = m_rises + rise_now;
      if (sum > 65535) sum = 65535;
      declare = 0;
      if (m_wcnt >= eff - 1) begin
        bit fl;
        fl = m_fell || fall_now;
        dev = (m_nom * m_tol) / 256;
        if (sum == 0) cls = fl ? 2 : 1;
        else if (sum < m_nom - dev) cls = 3;
        else if (sum > m_nom + dev) cls = 4;
        else cls = 0;
        mreq = (m_m < 3) ? 3 : m_m;
        if (cls != 0) begin
          int ri;
          ri = (m_run == 15) ? 15 : m_run + 1;
          declare = !m_fail && (ri >= mreq);
          m_run = ri;
          if (declare) m_fail = 1;
        end else begin
          m_run = 0; m_fail = 0;
        end
        m_cls = cls;
        win_ends++;
        m_wcnt = 0; m_rises = 0; m_fell = 0;
      end else begin
        m_wcnt++; m_rises = sum; m_fell = m_fell || fall_now;
      end
      m_evt = declare;
      if (p_clr && !m_lock) m_fcnt = 0;
      else if (declare && m_fcnt < 255) m_fcnt++;
      if (!m_lock) begin m_len = p_len; m_nom = p_nom; m_tol = p_tol; m_m = p_m; end
      m_lock = m_lock || p_lock;
      hq.push_front(p_mon);
      void'(hq.pop_back());
    end
    // per-cycle comparison against the model
    chk("R6", "cycle fail", fail_o, m_fail);
    chk("R7", "cycle event", evt_o, m_evt);
    chk("R4", "cycle class (R2 timing)", cls_o, m_cls);
    chk("R8", "cycle counter", fcnt_o, m_fcnt);
    if (rst_n && evt_o) evt_seen++;
  end

  task automatic wait_windows(int n);
    int target;
    target = win_ends + n;
    while (win_ends < target) begin @(negedge clk); #1; end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    cycles(5);
    chk("R1", "reset fail", fail_o, 0);
    chk("R1", "reset class", cls_o, 0);
    chk("R1", "reset counter", fcnt_o, 0);
    @(negedge clk); rst_n = 1'b1;
    cycles(1);
    chk("R1", "post-reset event", evt_o, 0);

    // R3: steady period 4, window 40 -> 10 per window, healthy
    wait_windows(5);
    chk("R3", "healthy class", cls_o, 0);
    chk("R3", "healthy fail", fail_o, 0);

    // R5: nominal 11, tol 26 -> lower limit 10, count 10 healthy
    cfg_nom = 16'd11;
    wait_windows(3);
    chk("R5", "lower limit class", cls_o, 0);

    // R4/R6: slow clock, period 6
    cfg_nom = 16'd10; mon_half = 3;
    wait_windows(5);
    chk("R4", "slow class", cls_o, 3);
    chk("R6", "slow fail", fail_o, 1);
    chk("R8", "counter after first failure", fcnt_o, 1);
    wait_windows(3);
    chk("R7", "no repeat event while failed", evt_seen, 1);

    // R6: one healthy window clears the flag
    mon_half = 2;
    wait_windows(3);
    chk("R6", "recovered fail", fail_o, 0);

    // R6: fast clock, not failed after two windows, failed after four
    mon_half = 1;
    wait_windows(2);
    chk("R6", "fail before M windows", fail_o, 0);
    wait_windows(2);
    chk("R6", "fail after M windows", fail_o, 1);
    chk("R4", "fast class", cls_o, 4);
    chk("R7", "second event", evt_seen, 2);

    // R4/R7: stuck clock while already failed, no new event
    mon_half = 0;
    wait_windows(4);
    chk("R4", "stuck class", cls_o, 1);
    chk("R7", "class change gives no event", evt_seen, 2);

    mon_half = 2;
    wait_windows(3);
    chk("R6", "recovered again", fail_o, 0);

    // R4: stopped - one falling edge, no rising edge, inside one window
    wait_windows(1);
    mon_half = 0; mon_clk = 1'b1;
    wait_windows(2);
    cycles(20);
    mon_clk = 1'b0;
    wait_windows(1);
    chk("R4", "stopped class", cls_o, 2);

    // R2: probe length below the floor behaves as 4 cycles
    cfg_len = 16'd1; cfg_nom = 16'd1; cfg_tol = 8'd0; mon_half = 2;
    wait_windows(10);
    chk("R2", "short window class", cls_o, 0);
    chk("R2", "short window fail", fail_o, 0);

    // R8: drive past 255 declarations
    for (int i = 0; i < 260; i++) begin
      mon_half = 0; cycles(20);
      mon_half = 2; cycles(20);
    end
    chk("R8", "saturated counter", fcnt_o, 255);

    // R9: clear while unlocked
    clr_in = 1'b1; @(negedge clk); clr_in = 1'b0; #1;
    chk("R9", "cleared counter", fcnt_o, 0);
    mon_half = 0; cycles(20);
    mon_half = 2; cycles(20);
    chk("R8", "counter after clear and one failure", fcnt_o, 1);

    // R10: lock, then try to clear and to change configuration
    lock_in = 1'b1; @(negedge clk); lock_in = 1'b0;
    cycles(2);
    clr_in = 1'b1; @(negedge clk); clr_in = 1'b0;
    cycles(2);
    chk("R9", "clear ignored when locked", fcnt_o, 1);
    cfg_nom = 16'd9; cfg_len = 16'd100; cfg_m = 4'd0;
    cycles(150);
    chk("R10", "locked config class", cls_o, 0);
    chk("R10", "locked config fail", fail_o, 0);

    finish_run();
  end
endmodule